// File: doc/BRIEF.md
# SPI Controller with Status Handshake

This block is a byte-wide serial peripheral port that a processor drives through three small registers: a control word, a read-only status word and a data word. The control word chooses whether the port is the clock owner (master) or follows an external clock (slave), which level the serial clock rests at, and which of the two clock-to-data timings is used. It also holds an interrupt enable. Writing the data word starts an 8-bit exchange, most significant bit first. In master mode the port generates the serial clock from the system clock through a fixed even divider. In slave mode it shifts only while its active-low select input is low.

When an exchange finishes, a completion flag in the status word is raised, and the interrupt output follows it while the enable is set. Clearing the flag takes two steps: first a status read that returns the flag set, then any access to the data word. Until that status read has been seen, writes to the data word are dropped, so software cannot start a new exchange over a result it has not yet acknowledged.

Registers are at word addresses 0 (control), 1 (status) and 2 (data). Read data is registered and appears on the cycle after the read strobe.

Top module: `spi_port`

## Requirements
- R1: After reset the control word reads 0 (slave, clock rests low, phase 0, interrupt disabled), the status word reads 0, and irq, sck_out and sdo are 0.
- R2: While no master exchange is running, sck_out rests at the polarity bit (control bit 3): low when it is 0 and high when it is 1.
- R3: In master mode (control bit 4 = 1), a data write starts an exchange that puts exactly 16 edges on sck_out, spaced CLK_DIV/2 clocks apart, and shifts the written byte out on sdo most significant bit first.
- R4: A status read returns the completion flag in bit 7, and every other bit is 0.
- R5: The completion flag and irq rise on the clock after the 16th master edge, which is 8*CLK_DIV+1 clocks after the clock that takes the data write.
- R6: The flag is cleared only by a data read or write that follows a status read that returned the flag set. A data access with no such status read before it leaves the flag set.
- R7: While the flag is set and no qualifying status read has been seen, a data write is ignored and starts no exchange.
- R8: irq is high exactly while the flag is set and the interrupt enable (control bit 7) is 1.
- R9: In slave mode the port shifts only while sel_n_in is low. It ignores clock edges while deselected, and it completes on the eighth sampling edge after selection.
- R10: With phase 0 (control bit 2 = 0) data is sampled on the leading clock edge and shifted on the trailing edge, and the first bit is on sdo before the first edge. With phase 1 the port shifts on the leading edge and samples on the trailing edge.
- R11: A data read returns the last received byte, zero-extended. A control read returns bits 7, 4, 3 and 2 as written and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data, valid the cycle after reg_rd |
| irq | output | 1 | Completion interrupt |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| sel_n_in | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
Register reads are sampled on the falling edge that follows the clock taking the strobe, because reg_rdata is one register deep. In master mode the bench counts falling edges from the clock that takes the data write: irq must still be low after 8*CLK_DIV clocks and high one clock later. The serial clock is watched at every falling edge, so edge count, spacing and the bit on sdo at each sampling edge are taken in the cycle each change lands. Slave inputs pass through a two-stage synchronizer and an edge register, so the bench holds every level of sck_in, sel_n_in and sdi for at least three clocks, and reads sdo and status only after six clocks have passed.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTL_IE   = 7;
  localparam int CTL_MST  = 4;
  localparam int CTL_POL  = 3;
  localparam int CTL_PHA  = 2;
  localparam int STAT_FLG = 7;

  typedef struct packed {
    logic ie;
    logic master;
    logic cpol;
    logic cpha;
  } ctl_t;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[0] <= INIT;
          else     st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[g] <= INIT;
          else     st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              busy,
  input  logic              done,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output ctl_t              ctl,
  output logic              start,
  output logic [DATA_W-1:0] tx_byte,
  output logic              flag,
  output logic              arm
);
  logic data_acc, stat_rd, clr;
  logic flag_d, arm_d;
  ctl_t ctl_d;
  logic [REG_W-1:0] rd_v;
  logic unused_hi;

  assign unused_hi = ^reg_wdata[REG_W-1:DATA_W];

  assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign stat_rd  = reg_rd && (reg_addr == ADDR_STAT);
  assign clr      = data_acc && flag && arm;
  assign start    = reg_wr && (reg_addr == ADDR_DATA) && (!flag || arm) && !busy;
  assign tx_byte  = reg_wdata[DATA_W-1:0];

  always_comb begin
    ctl_d = ctl;
    if (reg_wr && reg_addr == ADDR_CTL) begin
      ctl_d.ie     = reg_wdata[CTL_IE];
      ctl_d.master = reg_wdata[CTL_MST];
      ctl_d.cpol   = reg_wdata[CTL_POL];
      ctl_d.cpha   = reg_wdata[CTL_PHA];
    end

    flag_d = flag;
    if (clr)  flag_d = 1'b0;
    if (done) flag_d = 1'b1;

    arm_d = arm;
    if (stat_rd && flag)  arm_d = 1'b1;
    if (clr || start)     arm_d = 1'b0;

    rd_v = '0;
    case (reg_addr)
      ADDR_CTL: begin
        rd_v[CTL_IE]  = ctl.ie;
        rd_v[CTL_MST] = ctl.master;
        rd_v[CTL_POL] = ctl.cpol;
        rd_v[CTL_PHA] = ctl.cpha;
      end
      ADDR_STAT: rd_v[STAT_FLG] = flag;
      ADDR_DATA: rd_v[DATA_W-1:0] = rx_byte;
      default:   rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      flag      <= 1'b0;
      arm       <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ctl  <= ctl_d;
      flag <= flag_d;
      arm  <= arm_d;
      irq  <= flag_d && ctl_d.ie;
      if (reg_rd) reg_rdata <= rd_v;
    end
  end
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine #(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sck_in,
  input  logic              sel_n_in,
  input  logic              sdi,
  output logic              sck_out,
  output logic              sdo,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int HALF      = CLK_DIV / 2;
  localparam int DIV_W     = $clog2(HALF + 1);
  localparam int LAST_EDGE = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(LAST_EDGE + 1);

  logic [2:0] s_bus;
  logic s_sck, s_sel_n, s_sdi, sck_prev;
  logic m_busy, m_tick;
  logic [DIV_W-1:0]  div_cnt;
  logic [EDGE_W-1:0] edge_cnt;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
  logic lead_m, trail_m, lead_s, trail_s, s_act, s_edge;
  logic lead, trail, shift_ev, sample_ev, din;

  spi_port_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_in, sel_n_in, sdi}),
    .q   (s_bus)
  );
  assign {s_sck, s_sel_n, s_sdi} = s_bus;

  assign m_tick  = m_busy && (div_cnt == DIV_W'(HALF - 1));
  assign lead_m  = m_tick && !edge_cnt[0];
  assign trail_m = m_tick &&  edge_cnt[0];

  assign s_act   = !master && !s_sel_n;
  assign s_edge  = s_sck != sck_prev;
  assign lead_s  = s_act && s_edge && (s_sck != cpol);
  assign trail_s = s_act && s_edge && (s_sck == cpol);

  assign lead      = master ? lead_m  : lead_s;
  assign trail     = master ? trail_m : trail_s;
  assign shift_ev  = cpha ? lead  : trail;
  assign sample_ev = cpha ? trail : lead;
  assign din       = master ? sdi : s_sdi;
  assign rx_next   = sample_ev ? {rx_sh[DATA_W-2:0], din} : rx_sh;
  assign busy      = master ? m_busy : !s_sel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_busy   <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      sck_out  <= 1'b0;
      sdo      <= 1'b0;
      done     <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      done     <= 1'b0;
      sck_prev <= s_sck;
      if (start) begin
        tx_sh    <= cpha ? tx_byte : {tx_byte[DATA_W-2:0], 1'b0};
        if (!cpha) sdo <= tx_byte[DATA_W-1];
        m_busy   <= master;
        div_cnt  <= '0;
        edge_cnt <= '0;
      end else begin
        if (shift_ev) begin
          sdo   <= tx_sh[DATA_W-1];
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
        if (sample_ev) rx_sh <= rx_next;
        if (master) begin
          if (m_busy) begin
            if (m_tick) begin
              div_cnt  <= '0;
              sck_out  <= ~sck_out;
              edge_cnt <= edge_cnt + EDGE_W'(1);
              if (edge_cnt == EDGE_W'(LAST_EDGE - 1)) begin
                m_busy  <= 1'b0;
                done    <= 1'b1;
                rx_byte <= rx_next;
              end
            end else begin
              div_cnt <= div_cnt + DIV_W'(1);
            end
          end else begin
            sck_out <= cpol;
          end
        end else begin
          sck_out <= cpol;
          m_busy  <= 1'b0;
          if (s_sel_n) begin
            edge_cnt <= '0;
          end else if (sample_ev) begin
            if (edge_cnt == EDGE_W'(DATA_W - 1)) begin
              edge_cnt <= '0;
              done     <= 1'b1;
              rx_byte  <= rx_next;
            end else begin
              edge_cnt <= edge_cnt + EDGE_W'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             sck_out,
  input  logic             sck_in,
  input  logic             sel_n_in,
  input  logic             sdi,
  output logic             sdo
);
  ctl_t ctl;
  logic flag, arm, start, busy, done;
  logic ctl_ie, ctl_master, ctl_pol;
  logic [DATA_W-1:0] tx_byte, rx_byte;

  assign ctl_ie     = ctl.ie;
  assign ctl_master = ctl.master;
  assign ctl_pol    = ctl.cpol;

  spi_port_regs #(.REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .rx_byte   (rx_byte),
    .busy      (busy),
    .done      (done),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .ctl       (ctl),
    .start     (start),
    .tx_byte   (tx_byte),
    .flag      (flag),
    .arm       (arm)
  );

  spi_port_engine #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .master   (ctl.master),
    .cpol     (ctl.cpol),
    .cpha     (ctl.cpha),
    .start    (start),
    .tx_byte  (tx_byte),
    .sck_in   (sck_in),
    .sel_n_in (sel_n_in),
    .sdi      (sdi),
    .sck_out  (sck_out),
    .sdo      (sdo),
    .done     (done),
    .busy     (busy),
    .rx_byte  (rx_byte)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       reg_addr,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq,
  input logic             sck_out,
  input logic             flag,
  input logic             arm,
  input logic             ie,
  input logic             master,
  input logic             cpol,
  input logic             busy,
  input logic             done,
  input logic             start
);
  localparam int CW = $clog2(2 * DATA_W + 2);

  logic sck_q, tog_now;
  logic [CW-1:0] tog;

  assign tog_now = sck_out != sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      tog   <= '0;
    end else begin
      sck_q <= sck_out;
      tog   <= start ? '0 : tog + CW'(tog_now);
    end
  end

  a_r2_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck_out == cpol));

  a_r3_sixteen_edges: assert property (@(posedge clk) disable iff (rst)
    (done && master) |-> ((tog + CW'(tog_now)) == CW'(2 * DATA_W)));

  a_r4_status_zero_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_STAT) |=>
      ((reg_rdata & ~(REG_W'(1) << STAT_FLG)) == '0));

  a_r5_flag_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> flag);

  a_r6_clear_sequence: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past((reg_rd || reg_wr) && reg_addr == ADDR_DATA && arm));

  a_r7_write_refused: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_DATA && flag && !arm && master && !busy) |=> !busy);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie));
endmodule

bind spi_port spi_port_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .sck_out   (sck_out),
  .flag      (flag),
  .arm       (arm),
  .ie        (ctl_ie),
  .master    (ctl_master),
  .cpol      (ctl_pol),
  .busy      (busy),
  .done      (done),
  .start     (start)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq, sck_out, sdo, sdi;
  logic sck_in = 1'b0, sel_n_in = 1'b1, sdi_s = 1'b0, lb = 1'b1;
  logic tb_cpol = 1'b0, tb_cpha = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 0;

  int mon_edges = 0, mon_gap = 100, mon_gap_bad = 0;
  logic mon_prev = 1'b0;
  logic [7:0] mon_cap = '0;

  always #2.5 clk = ~clk;

  assign sdi = lb ? sdo : sdi_s;

  spi_port #(.REG_W(16), .DATA_W(8), .CLK_DIV(DIV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck_out(sck_out),
    .sck_in(sck_in), .sel_n_in(sel_n_in), .sdi(sdi), .sdo(sdo)
  );

  always @(negedge clk) begin
    mon_gap++;
    if (sck_out !== mon_prev) begin
      mon_edges++;
      if (mon_gap < 4 * HALF && mon_gap != HALF) mon_gap_bad++;
      mon_gap = 0;
      if ((sck_out != tb_cpol) ^ tb_cpha) mon_cap = {mon_cap[6:0], sdo};
    end
    mon_prev = sck_out;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 sck_out", {15'd0, sck_out}, 16'd0);
    chk("R1 sdo", {15'd0, sdo}, 16'd0);
    rd(2'd0, v); chk("R1 control", v, 16'h0000);
    rd(2'd1, v); chk("R1 status", v, 16'h0000);
  endtask

  task automatic t_ctl();
    logic [15:0] v;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R11 control readback", v, 16'h009C);
    repeat (2) @(negedge clk);
    chk("R2 idle high", {15'd0, sck_out}, 16'd1);
    wr(2'd0, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R2 idle low", {15'd0, sck_out}, 16'd0);
  endtask

  task automatic t_master(input logic pol, input logic pha, input logic [7:0] b);
    int e0, g0;
    lb = 1'b1; tb_cpol = pol; tb_cpha = pha;
    wr(2'd0, {8'd0, 1'b1, 2'b00, 1'b1, pol, pha, 2'b00});
    repeat (10) @(negedge clk);
    e0 = mon_edges; g0 = mon_gap_bad;
    wr(2'd2, {8'd0, b});
    repeat (8 * DIV) @(negedge clk);
    chk("R5 irq not yet", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R5 R8 irq rises", {15'd0, irq}, 16'd1);
    chk("R3 edge count", 16'(mon_edges - e0), 16'd16);
    chk("R3 half period", 16'(mon_gap_bad - g0), 16'd0);
    chk("R3 R10 sdo bits at sampling edges", {8'd0, mon_cap}, {8'd0, b});
    chk("R2 back to idle", {15'd0, sck_out}, {15'd0, pol});
  endtask

  task automatic t_clear(input logic [7:0] b);
    logic [15:0] v;
    rd(2'd1, v); chk("R4 status flag", v, 16'h0080);
    rd(2'd2, v); chk("R11 received byte", v, {8'd0, b});
    chk("R6 irq cleared", {15'd0, irq}, 16'd0);
    rd(2'd1, v); chk("R6 status after clear", v, 16'h0000);
  endtask

  task automatic t_refuse(input logic pol, input logic pha, input logic [7:0] old_b,
                          input logic [7:0] new_b);
    logic [15:0] v;
    int e0;
    e0 = mon_edges;
    wr(2'd2, 16'h00FF);
    repeat (20) @(negedge clk);
    chk("R7 no exchange started", 16'(mon_edges - e0), 16'd0);
    chk("R7 flag kept", {15'd0, irq}, 16'd1);
    rd(2'd2, v); chk("R7 byte not overwritten", v, {8'd0, old_b});
    chk("R6 data read alone keeps flag", {15'd0, irq}, 16'd1);
    rd(2'd1, v); chk("R6 status seen", v, 16'h0080);
    t_master(pol, pha, new_b);
  endtask

  task automatic t_slave(input logic pol, input logic pha, input logic [7:0] txb,
                         input logic [7:0] mb);
    logic [15:0] v;
    logic [7:0] got;
    got = '0;
    lb = 1'b0; tb_cpol = pol; tb_cpha = pha;
    @(negedge clk); sck_in = pol; sel_n_in = 1'b1;
    wr(2'd0, {8'd0, 1'b1, 2'b00, 1'b0, pol, pha, 2'b00});
    repeat (6) @(negedge clk);
    wr(2'd2, {8'd0, txb});
    for (int k = 0; k < 4; k++) begin
      sck_in = ~sck_in;
      repeat (6) @(negedge clk);
    end
    chk("R9 no completion while deselected", {15'd0, irq}, 16'd0);
    sel_n_in = 1'b0;
    repeat (6) @(negedge clk);
    if (!pha) chk("R10 first bit before first edge", {15'd0, sdo}, {15'd0, txb[7]});
    for (int i = 0; i < 8; i++) begin
      if (!pha) begin
        sdi_s = mb[7-i];
        repeat (3) @(negedge clk);
        got = {got[6:0], sdo};
        sck_in = ~pol;
        repeat (6) @(negedge clk);
        sck_in = pol;
        repeat (6) @(negedge clk);
      end else begin
        sck_in = ~pol;
        repeat (6) @(negedge clk);
        sdi_s = mb[7-i];
        repeat (3) @(negedge clk);
        got = {got[6:0], sdo};
        sck_in = pol;
        repeat (6) @(negedge clk);
      end
      if (i == 6) chk("R9 not done before eighth sample", {15'd0, irq}, 16'd0);
    end
    chk("R9 done after eighth sample", {15'd0, irq}, 16'd1);
    chk("R9 R10 slave transmit bits", {8'd0, got}, {8'd0, txb});
    sel_n_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd1, v); chk("R4 slave status", v, 16'h0080);
    rd(2'd2, v); chk("R9 slave received byte", v, {8'd0, mb});
    chk("R6 slave flag cleared", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_master(1'b0, 1'b0, 8'hA5);
    t_clear(8'hA5);
    t_master(1'b1, 1'b1, 8'h3C);
    t_refuse(1'b1, 1'b1, 8'h3C, 8'h5A);
    t_clear(8'h5A);
    t_master(1'b0, 1'b1, 8'h96);
    t_clear(8'h96);
    t_master(1'b1, 1'b0, 8'h69);
    t_clear(8'h69);
    t_slave(1'b0, 1'b0, 8'hC3, 8'h5E);
    t_slave(1'b1, 1'b1, 8'h81, 8'h7E);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule